// File: doc/BRIEF.md
# Split-Page Hamming ECC Engine

This block computes a Hamming-style error-correcting code over a flash page while its bytes stream through a byte-wide data port. The page has two halves of 2^IDX_W bytes each, and each half gets its own independent code. For a page of 512 bytes, IDX_W is 8.

On a program the controller enables the engine and pushes the page. It then lowers the enable, which freezes the two codes, and reads them back through the same data port while the ECC-access select is high.

On a page read the controller streams the data the same way. It then writes the six stored code bytes into the port with access selected, and reads one packed check word. For each half the check word reports one of three results: clean, a single flipped bit with its byte index and bit position, or an uncorrectable error. This block does not apply the repair. Software flips the reported bit.

Top module: `pecc_page_engine`

## Requirements
- R1: After reset `dp_rdata` is zero, the byte count, the stored-code buffer and both codes are clear, and the first access read returns 32'h00C0_0000.
- R2: A rising edge of `ecc_en` clears both codes, the page byte count and the stored-code buffer.
- R3: While `ecc_en` is low, data bytes are ignored and both codes keep their values.
- R4: Only the first 2·2^IDX_W data bytes after a clear are accumulated. Bytes 0 to 2^IDX_W−1 go to half 0 and the rest go to half 1. Later bytes are ignored until the next clear.
- R5: A half's code is 22 bits. Bit k (k = 0..10) is the parity of all data bits whose address {byte index within the half, bit position} has bit k set. Bit 11+k is the parity of all data bits whose address has bit k clear. The code word read back is {8'h00, 2'b11, code}.
- R6: A byte strobed while `ecc_acc` is high loads the stored-code buffer in this order: half 0 bytes 0, 1, 2, then half 1 bytes 0, 1, 2. Byte n of a half maps to code bits 8n+7:8n, and the top two bits are dropped. Strobes after the sixth are ignored until the next clear.
- R7: A read strobe with `ecc_acc` high and `ecc_en` low places a word on `dp_rdata` one cycle later. The words follow the cyclic order half-0 code, half-1 code, check word. Lowering `ecc_acc` restarts the order. `dp_rdata` holds its value at all other times.
- R8: A read strobe with `ecc_acc` high while `ecc_en` is high is a flush. It clears the same state as R2 and returns zero.
- R9: In each 16-bit half field of the check word, a zero syndrome gives 16'h0000. A syndrome whose low and high 11-bit parts are bitwise complements is correctable and gives bit 12 set, bits 10:8 holding the bit position, and bits 7:0 holding the byte index. Any other syndrome gives 16'h8000.
- R10: The check word carries half 0 in bits 15:0 and half 1 in bits 31:16. When half 0 is uncorrectable, bits 31:16 read zero.
- R11: The two halves are independent. Changing bytes of one half never alters the other half's code or field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ecc_en | input | 1 | Accumulate enable; its rising edge restarts the page |
| ecc_acc | input | 1 | Selects ECC access on the data port |
| byte_vld | input | 1 | A byte moves through the data port this cycle |
| dp_byte | input | 8 | Byte on the data port |
| dp_rd | input | 1 | Read strobe on the data port |
| dp_rdata | output | 32 | Registered read word |

## Verification
The assertions assume that every cycle's inputs are valid 0/1 values, that reset is applied before any stimulus, and that a read strobe and a byte strobe of the same access type may share a cycle. The bench drives all inputs on the falling clock edge. It holds `ecc_en` low for one cycle before each page so that every page starts on a real rising edge, and it changes `ecc_acc` only between transfers. Every single-bit flip across both halves is swept on a configuration with 16-byte halves. Double-bit and mixed patterns cover the uncorrectable and masking cases.

// File: rtl/pecc_pkg.sv
package pecc_pkg;

  localparam int SLOT_W    = 11;
  localparam int CODE_W    = 2 * SLOT_W;
  localparam int NUM_HALF  = 2;
  localparam int REF_BYTES = 3 * NUM_HALF;
  localparam int FIELD_W   = 16;
  localparam int CORR_BIT  = 12;
  localparam int FAIL_BIT  = 15;

  // Contribution of one data byte at a given in-half index to the code.
  function automatic logic [CODE_W-1:0] code_step(input logic [7:0] d,
                                                  input logic [7:0] idx);
    logic [SLOT_W-1:0] hi;
    logic [SLOT_W-1:0] lo;
    logic [7:0]        m;
    logic              p;
    p  = ^d;
    hi = '0;
    lo = '0;
    for (int k = 0; k < 3; k++) begin
      for (int b = 0; b < 8; b++) m[b] = 1'((b >> k) & 1);
      hi[k] = ^(d & m);
      lo[k] = ^(d & ~m);
    end
    for (int k = 0; k < 8; k++) begin
      hi[3+k] = p & idx[k];
      lo[3+k] = p & ~idx[k];
    end
    return {lo, hi};
  endfunction

  // Classify the syndrome of one half into its 16-bit report field.
  function automatic logic [FIELD_W-1:0] eval_half(input logic [CODE_W-1:0] calc,
                                                    input logic [CODE_W-1:0] ref_c);
    logic [CODE_W-1:0] s;
    s = calc ^ ref_c;
    if (s == '0) return '0;
    if ((s[SLOT_W-1:0] ^ s[CODE_W-1:SLOT_W]) == '1)
      return {5'b00010, s[2:0], s[10:3]};
    return 16'h8000;
  endfunction

  function automatic logic [31:0] code_word(input logic [CODE_W-1:0] c);
    return {8'h00, 2'b11, c};
  endfunction

endpackage

// File: rtl/pecc_half_acc.sv
module pecc_half_acc
  import pecc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              take,
  input  logic [7:0]        data,
  input  logic [7:0]        idx,
  output logic [CODE_W-1:0] code
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    code <= '0;
    else if (clr)  code <= '0;
    else if (take) code <= code ^ code_step(data, idx);
  end

endmodule

// File: rtl/pecc_syndrome.sv
module pecc_syndrome
  import pecc_pkg::*;
(
  input  logic [CODE_W-1:0]  calc,
  input  logic [CODE_W-1:0]  ref_code,
  output logic [FIELD_W-1:0] field,
  output logic               corr,
  output logic               uncorr
);

  assign field  = eval_half(calc, ref_code);
  assign corr   = field[CORR_BIT];
  assign uncorr = field[FAIL_BIT];

endmodule

// File: rtl/pecc_page_engine.sv
module pecc_page_engine
  import pecc_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ecc_en,
  input  logic        ecc_acc,
  input  logic        byte_vld,
  input  logic [7:0]  dp_byte,
  input  logic        dp_rd,
  output logic [31:0] dp_rdata
);

  localparam int HALF_BYTES = 1 << IDX_W;
  localparam int PAGE_BYTES = HALF_BYTES * NUM_HALF;
  localparam int CNT_W      = IDX_W + 2;
  localparam int RCNT_W     = 3;

  logic              en_q;
  logic [CNT_W-1:0]  cnt;
  logic [RCNT_W-1:0] ref_cnt;
  logic [7:0]        ref_q [REF_BYTES];
  logic [1:0]        ptr;

  // Named events
  logic en_rise, flush, clr, take, ref_wr, acc_rd;
  assign en_rise = ecc_en & ~en_q;
  assign flush   = dp_rd & ecc_acc & ecc_en;
  assign clr     = en_rise | flush;
  assign take    = byte_vld & ~ecc_acc & ecc_en & (cnt < CNT_W'(PAGE_BYTES));
  assign ref_wr  = byte_vld & ecc_acc & (ref_cnt < RCNT_W'(REF_BYTES));
  assign acc_rd  = dp_rd & ecc_acc & ~ecc_en;

  logic [7:0] cur_idx;
  assign cur_idx = 8'(cnt[IDX_W-1:0]);

  logic [CODE_W-1:0]  code_w  [NUM_HALF];
  logic [CODE_W-1:0]  ref_w   [NUM_HALF];
  logic [FIELD_W-1:0] field_w [NUM_HALF];
  logic [NUM_HALF-1:0] corr_w, uncorr_w;

  for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
    logic take_h;
    assign take_h   = take & (cnt[IDX_W] == 1'(h));
    assign ref_w[h] = CODE_W'({ref_q[3*h+2], ref_q[3*h+1], ref_q[3*h]});

    pecc_half_acc u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .take  (take_h),
      .data  (dp_byte),
      .idx   (cur_idx),
      .code  (code_w[h])
    );

    pecc_syndrome u_syn (
      .calc     (code_w[h]),
      .ref_code (ref_w[h]),
      .field    (field_w[h]),
      .corr     (corr_w[h]),
      .uncorr   (uncorr_w[h])
    );
  end

  logic [31:0] check_word;
  assign check_word = {uncorr_w[0] ? 16'h0000 : field_w[1], field_w[0]};

  logic [31:0] rd_word;
  always_comb begin
    case (ptr)
      2'd0:    rd_word = code_word(code_w[0]);
      2'd1:    rd_word = code_word(code_w[1]);
      default: rd_word = check_word;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      cnt  <= '0;
    end else begin
      en_q <= ecc_en;
      if (clr)       cnt <= '0;
      else if (take) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt <= '0;
      for (int i = 0; i < REF_BYTES; i++) ref_q[i] <= '0;
    end else if (clr) begin
      ref_cnt <= '0;
      for (int i = 0; i < REF_BYTES; i++) ref_q[i] <= '0;
    end else if (ref_wr) begin
      ref_q[ref_cnt] <= dp_byte;
      ref_cnt        <= ref_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr      <= '0;
      dp_rdata <= '0;
    end else begin
      if (!ecc_acc)    ptr <= '0;
      else if (acc_rd) ptr <= (ptr == 2'd2) ? 2'd0 : ptr + 2'd1;
      if (flush)       dp_rdata <= '0;
      else if (acc_rd) dp_rdata <= rd_word;
    end
  end

  // ---------------- assertions ----------------
  logic [2*CODE_W-1:0] code_cat;
  assign code_cat = {code_w[1], code_w[0]};

  p_clear_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> (cnt == '0 && ref_cnt == '0 && code_cat == '0));

  p_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ecc_en |=> $stable(code_cat) && $stable(cnt));

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(PAGE_BYTES));

  p_ref_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_cnt <= RCNT_W'(REF_BYTES));

  p_rdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(dp_rd && ecc_acc) |=> $stable(dp_rdata));

  p_flush_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (dp_rdata == 32'h0 && cnt == '0 && code_cat == '0));

  p_status_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({corr_w[0], uncorr_w[0]}) && $onehot0({corr_w[1], uncorr_w[1]}));

  p_stop_after_fail_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && ptr == 2'd2) |=> (!dp_rdata[15] || dp_rdata[31:16] == 16'h0));

endmodule

// File: tb/pecc_page_engine_tb_top.sv
`timescale 1ns/1ps
module pecc_page_engine_tb_top;

  localparam int IDX_W = 4;
  localparam int HB    = 1 << IDX_W;
  localparam int PB    = 2 * HB;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ecc_en = 1'b0, ecc_acc = 1'b0, byte_vld = 1'b0, dp_rd = 1'b0;
  logic [7:0]  dp_byte = 8'h00;
  logic [31:0] dp_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] pg [PB];

  always #2 clk = ~clk;

  pecc_page_engine #(.IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ecc_en(ecc_en), .ecc_acc(ecc_acc),
    .byte_vld(byte_vld), .dp_byte(dp_byte), .dp_rd(dp_rd), .dp_rdata(dp_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Model: per-bit parity over the address of each set bit.
  function automatic logic [21:0] m_code(input int h, input int f0, input int f1,
                                         input int f2);
    logic [10:0] hi = '0;
    logic [10:0] lo = '0;
    for (int j = 0; j < HB; j++) begin
      for (int b = 0; b < 8; b++) begin
        int flat = (h*HB + j)*8 + b;
        logic v = pg[h*HB+j][b] ^ (flat == f0) ^ (flat == f1) ^ (flat == f2);
        if (v) begin
          int a = j*8 + b;
          for (int k = 0; k < 11; k++)
            if (((a >> k) & 1) == 1) hi[k] = ~hi[k]; else lo[k] = ~lo[k];
        end
      end
    end
    return {lo, hi};
  endfunction

  function automatic logic [15:0] m_field(input logic [21:0] c, input logic [21:0] r);
    logic [21:0] s = c ^ r;
    if (s == 0) return 16'h0;
    if (s[21:11] == ~s[10:0]) return {5'b00010, s[2:0], s[10:3]};
    return 16'h8000;
  endfunction

  function automatic logic [31:0] m_word(input logic [21:0] c);
    return {8'h00, 2'b11, c};
  endfunction

  function automatic logic [31:0] m_check(input int f0, input int f1, input int f2);
    logic [15:0] a = m_field(m_code(0, f0, f1, f2), m_code(0, -1, -1, -1));
    logic [15:0] b = m_field(m_code(1, f0, f1, f2), m_code(1, -1, -1, -1));
    return a[15] ? {16'h0, a} : {b, a};
  endfunction

  task automatic tick; @(negedge clk); endtask

  task automatic push(input logic [7:0] b);
    byte_vld = 1'b1; dp_byte = b; tick; byte_vld = 1'b0;
  endtask

  task automatic start_page;
    ecc_acc = 1'b0; ecc_en = 1'b0; tick; ecc_en = 1'b1; tick;
  endtask

  task automatic stop_page; ecc_en = 1'b0; tick; endtask

  task automatic send_page(input int f0, input int f1, input int f2);
    for (int j = 0; j < PB; j++) begin
      logic [7:0] b = pg[j];
      for (int q = 0; q < 8; q++) begin
        int flat = j*8 + q;
        if (flat == f0 || flat == f1 || flat == f2) b[q] = ~b[q];
      end
      push(b);
    end
  endtask

  task automatic read_word(output logic [31:0] w);
    ecc_acc = 1'b1; dp_rd = 1'b1; tick; dp_rd = 1'b0; w = dp_rdata;
  endtask

  task automatic desel; ecc_acc = 1'b0; tick; endtask

  task automatic load_ref;
    logic [31:0] c0 = m_word(m_code(0, -1, -1, -1));
    logic [31:0] c1 = m_word(m_code(1, -1, -1, -1));
    ecc_acc = 1'b1;
    push(c0[7:0]); push(c0[15:8]); push(c0[23:16]);
    push(c1[7:0]); push(c1[15:8]); push(c1[23:16]);
  endtask

  task automatic run_check(input int f0, input int f1, input int f2,
                           output logic [31:0] w0, output logic [31:0] w1,
                           output logic [31:0] w2);
    start_page; send_page(f0, f1, f2); stop_page;
    load_ref;
    read_word(w0); read_word(w1); read_word(w2);
    desel;
  endtask

  task automatic fill(input int seed);
    for (int j = 0; j < PB; j++) pg[j] = 8'(j*29 + seed) ^ 8'h5A;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] w0, w1, w2, w3, e0, e1;
    tick; tick; rst_n = 1'b1; tick;

    // R1 reset state
    chk(dp_rdata == 32'h0, "R1 rdata after reset", dp_rdata, 32'h0);
    read_word(w0);
    chk(w0 == 32'h00C0_0000, "R1 code0 after reset", w0, 32'h00C0_0000);
    desel;

    // R5 / R9 clean pages with several patterns
    for (int pat = 0; pat < 3; pat++) begin
      if (pat == 0) fill(7);
      else for (int j = 0; j < PB; j++) pg[j] = (pat == 1) ? 8'h00 : 8'hFF;
      run_check(-1, -1, -1, w0, w1, w2);
      e0 = m_word(m_code(0, -1, -1, -1)); e1 = m_word(m_code(1, -1, -1, -1));
      chk(w0 == e0, "R5 code half0", w0, e0);
      chk(w1 == e1, "R5 code half1", w1, e1);
      chk(w2 == 32'h0, "R9 clean check word", w2, 32'h0);
    end

    // R9 / R11 sweep of every single-bit flip in both halves
    fill(3);
    for (int fb = 0; fb < PB*8; fb++) begin
      logic [31:0] ex;
      logic [15:0] fld;
      run_check(fb, -1, -1, w0, w1, w2);
      fld = {5'b00010, 3'(fb % 8), 8'((fb / 8) % HB)};
      ex = (fb < HB*8) ? {16'h0, fld} : {fld, 16'h0};
      chk(w2 == ex, "R9 single-bit report", w2, ex);
      e0 = m_word(m_code(0, fb, -1, -1));
      e1 = m_word(m_code(1, fb, -1, -1));
      chk(w0 == e0 && w1 == e1, "R11 halves independent", fb < HB*8 ? w0 : w1,
          fb < HB*8 ? e0 : e1);
    end

    // R10 uncorrectable half0 masks half1; R9 uncorrectable in half1
    run_check(3, 9, HB*8 + 12, w0, w1, w2);
    chk(w2 == 32'h0000_8000, "R10 mask after half0 fail", w2, 32'h0000_8000);
    chk(w2 == m_check(3, 9, HB*8 + 12), "R10 model agrees", w2, m_check(3, 9, HB*8 + 12));
    run_check(HB*8 + 2, HB*8 + 13, -1, w0, w1, w2);
    chk(w2 == 32'h8000_0000, "R9 uncorrectable half1", w2, 32'h8000_0000);

    // R6 seventh stored byte ignored
    start_page; send_page(-1, -1, -1); stop_page;
    load_ref; push(8'hFF);
    read_word(w0); read_word(w1); read_word(w2); desel;
    chk(w2 == 32'h0, "R6 extra stored byte ignored", w2, 32'h0);

    // R4 bytes past the page end ignored
    e0 = m_word(m_code(0, -1, -1, -1)); e1 = m_word(m_code(1, -1, -1, -1));
    start_page; send_page(-1, -1, -1);
    for (int x = 0; x < 5; x++) push(8'(8'hA3 + x));
    stop_page;
    read_word(w0); read_word(w1); desel;
    chk(w0 == e0, "R4 overflow half0", w0, e0);
    chk(w1 == e1, "R4 overflow half1", w1, e1);

    // R3 bytes while disabled ignored
    for (int x = 0; x < 4; x++) push(8'(8'h11 * (x + 1)));
    read_word(w0); read_word(w1); desel;
    chk(w0 == e0 && w1 == e1, "R3 frozen while disabled", w0, e0);

    // R2 rising enable clears codes and stored bytes
    load_ref;
    start_page; stop_page;
    read_word(w0); read_word(w1); read_word(w2); desel;
    chk(w0 == 32'h00C0_0000 && w1 == 32'h00C0_0000, "R2 codes cleared", w0, 32'h00C0_0000);
    chk(w2 == 32'h0, "R2 stored bytes cleared", w2, 32'h0);

    // R8 flush mid-page
    start_page;
    for (int x = 0; x < 10; x++) push(8'(x * 13 + 1));
    read_word(w0);
    chk(w0 == 32'h0, "R8 flush returns zero", w0, 32'h0);
    ecc_acc = 1'b0;
    send_page(-1, -1, -1); stop_page;
    read_word(w0); read_word(w1);
    chk(w0 == e0 && w1 == e1, "R8 flush restarts count", w0, e0);

    // R7 readout order, hold and restart
    read_word(w2); read_word(w3);
    chk(w3 == e0, "R7 cyclic order", w3, e0);
    tick; tick; tick;
    chk(dp_rdata == w3, "R7 hold when idle", dp_rdata, w3);
    ecc_acc = 1'b0; dp_rd = 1'b1; tick; dp_rd = 1'b0;
    chk(dp_rdata == w3, "R7 read without access", dp_rdata, w3);
    read_word(w0); read_word(w1); desel;
    read_word(w0); desel;
    chk(w0 == e0, "R7 restart after deselect", w0, e0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule